// File: doc/BRIEF.md
# Reset and Battery Backup Sequencer

This block decides when the rest of the chip may run. It sits on the always-on 32.768 kHz timer clock and watches two asynchronous inputs: a main-power-good flag and an active-low external reset. When main power drops, it moves the chip into a low-power backup mode. In that mode the register reset is held, every gated clock enable is dropped so the clock generator parks those clocks high, and retained RAM is told to hold its contents. It also forces the chip's outputs into safe states, chosen per pin class. When power returns, it enforces a power-up wait, waits for the external reset to be released, and then counts a short restart delay before it enables the clocks and releases the register reset together.

During normal operation a low level on the external reset starts a qualification window. A pulse that is shorter than the minimum width is dropped and has no effect. A pulse that is long enough puts the chip into a soft reset, which lasts until the reset input returns high. Release from a soft reset then goes through the same restart delay as release after power-up.

The sequencer has six states:
- ST_BACKUP: main power is absent.
- ST_PWRUP: the power-up wait.
- ST_RESTART: the restart delay.
- ST_RUN: normal operation.
- ST_QUAL: a low reset input is being qualified.
- ST_SOFTRST: a qualified soft reset is in progress.

The transitions are:
- power-return: ST_BACKUP to ST_PWRUP.
- wait-done: ST_PWRUP to ST_RESTART, once the wait has expired and the reset input is high.
- release: ST_RESTART to ST_RUN, after the delay.
- restart-abort: ST_RESTART to ST_SOFTRST, when the reset input goes low.
- low-seen: ST_RUN to ST_QUAL.
- glitch-drop: ST_QUAL to ST_RUN.
- qualified: ST_QUAL to ST_SOFTRST.
- reset-end: ST_SOFTRST to ST_RESTART.
- power-loss: any state to ST_BACKUP. Power-loss has the highest priority.

Top module: `rbb_ctrl`

## Requirements
- R1: While `rst_n` is low, the block is in backup: `reg_rst_n`=0, `gclk_en`=0, `ram_retain`=1 and all pins are forced, whatever the value of `pwr_good`.
- R2: When `pwr_good` falls, backup is reached on the 3rd rising clock edge after the fall, from any state. This is two synchroniser flops plus the state register. On that edge `reg_rst_n` and every `gclk_en` bit go to 0. After only 2 edges the previous outputs still hold.
- R3: In backup, `tx_o` and `clkout_o` are driven 0, `strb_oe_o` is 0 (strobes and chip selects are high-impedance) and `bidir_oe_o` is 0. Outside backup, `tx_o`, `clkout_o` and `bidir_oe_o` pass the core values and `strb_oe_o` is all ones.
- R4: With `ext_rst_n` already high, the register reset is released on exactly edge PWRUP_CYC+RESTART_CYC+3 after `pwr_good` rises. With the defaults this is 3277+10+3 = 3290 edges, from a 100 ms wait at 32768 Hz rounded up. `ram_retain` drops on edge 3.
- R5: If `ext_rst_n` stays low for longer than the power-up wait, the release comes on edge RESTART_CYC+3 (13) after `ext_rst_n` rises.
- R6: During operation, an `ext_rst_n` low level that is held for MIN_LOW_CYC clock samples enters soft reset. MIN_LOW_CYC is 4 by default, from 100 µs rounded up. Soft reset clears `reg_rst_n` and `gclk_en` on edge MIN_LOW_CYC+2 (6) after the fall.
- R7: An `ext_rst_n` low pulse of MIN_LOW_CYC-1 cycles is ignored: `reg_rst_n` and `gclk_en` stay 1 throughout the pulse and after it.
- R8: On leaving soft reset, `reg_rst_n` and all `gclk_en` bits rise together on edge RESTART_CYC+3 (13) after `ext_rst_n` rises. No `gclk_en` bit is ever 1 while `reg_rst_n` is 0.
- R9: A low `ext_rst_n` during the restart delay returns the block to soft reset. The release is then counted again from the next rise: the clocks stay held and the release falls on edge 13 after that rise.
- R10: `ram_retain` is 1 only in backup. It is 0 during power-up wait, restart and soft reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on timer clock (32.768 kHz nominal) |
| rst_n | input | 1 | Asynchronous reset of the always-on domain, active low |
| pwr_good | input | 1 | Main power present, asynchronous |
| ext_rst_n | input | 1 | External reset request, active low, asynchronous |
| core_tx | input | TX_W (3) | Serial transmit values from the core |
| core_clkout | input | CKO_W (2) | Clock output values from the core |
| core_bidir_oe | input | BIDIR_W (8) | Bidirectional pin output enables from the core |
| reg_rst_n | output | 1 | Register reset for the switched domain, active low |
| gclk_en | output | NUM_GCLK (3) | Gated clock enables; 0 means that clock is held high |
| ram_retain | output | 1 | RAM retention request, high only in backup |
| tx_o | output | TX_W (3) | Serial transmit pins after forcing |
| clkout_o | output | CKO_W (2) | Clock output pins after forcing |
| strb_oe_o | output | STRB_W (7) | Output enables of memory strobes and chip selects |
| bidir_oe_o | output | BIDIR_W (8) | Output enables of bidirectional pins after forcing |

## Verification
Every result waits on the same chain: two synchroniser flops, then the state register. Because of this, nothing moves before the 3rd rising edge after an input change. The outputs are decoded straight from the state, so each result is due at a known edge: edge 3 for backup entry, edge 6 for soft-reset entry, edge 13 for release from soft reset and edge 3290 for power-up. The bench drives each input at a falling edge and counts rising edges exactly. It samples at the falling edge one cycle before each due edge, where the old value must still hold, and again just after the due edge, where the new value must appear.

// File: rtl/rbb_pkg.sv
package rbb_pkg;

    typedef enum logic [2:0] {
        ST_BACKUP,
        ST_PWRUP,
        ST_RESTART,
        ST_RUN,
        ST_QUAL,
        ST_SOFTRST
    } rbb_state_e;

    // Number of clock cycles that covers a time in microseconds, rounded up.
    function automatic int cyc_from_us(longint hz, longint us);
        return int'((hz * us + 64'd999999) / 64'd1000000);
    endfunction

endpackage

// File: rtl/rbb_sync.sv
module rbb_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= {STAGES{RST_VAL}};
        else        sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/rbb_seq.sv
module rbb_seq
    import rbb_pkg::*;
#(
    parameter int PWRUP_CYC   = 3277,
    parameter int MIN_LOW_CYC = 4,
    parameter int RESTART_CYC = 10,
    parameter int NUM_GCLK    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_s,
    input  logic                ext_s,
    output logic                reg_rst_n,
    output logic [NUM_GCLK-1:0] gclk_en,
    output logic                backup
);
    localparam int CNT_MAX = (PWRUP_CYC > RESTART_CYC)
                           ? ((PWRUP_CYC > MIN_LOW_CYC) ? PWRUP_CYC : MIN_LOW_CYC)
                           : ((RESTART_CYC > MIN_LOW_CYC) ? RESTART_CYC : MIN_LOW_CYC);
    localparam int CNT_W = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] P_LAST   = CNT_W'(PWRUP_CYC - 1);
    localparam logic [CNT_W-1:0] R_LAST   = CNT_W'(RESTART_CYC - 1);
    // The sample taken on entry to ST_QUAL is the first of MIN_LOW_CYC.
    localparam logic [CNT_W-1:0] M_LAST   = CNT_W'(MIN_LOW_CYC - 2);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(CNT_MAX - 1);

    rbb_state_e       state, nxt;
    logic [CNT_W-1:0] cnt;
    logic             cnt_clr;

    // Next state and counter control
    always_comb begin
        nxt     = state;
        cnt_clr = 1'b1;
        unique case (state)
            ST_BACKUP: begin
                if (pwr_s) nxt = ST_PWRUP;                       // power-return
            end
            ST_PWRUP: begin
                cnt_clr = 1'b0;
                if (cnt == P_LAST && ext_s) begin                 // wait-done
                    nxt     = ST_RESTART;
                    cnt_clr = 1'b1;
                end
            end
            ST_RESTART: begin
                cnt_clr = 1'b0;
                if (!ext_s) begin                                 // restart-abort
                    nxt     = ST_SOFTRST;
                    cnt_clr = 1'b1;
                end else if (cnt == R_LAST) begin                 // release
                    nxt     = ST_RUN;
                    cnt_clr = 1'b1;
                end
            end
            ST_RUN: begin
                if (!ext_s) nxt = ST_QUAL;                        // low-seen
            end
            ST_QUAL: begin
                cnt_clr = 1'b0;
                if (ext_s) begin                                  // glitch-drop
                    nxt     = ST_RUN;
                    cnt_clr = 1'b1;
                end else if (cnt == M_LAST) begin                 // qualified
                    nxt     = ST_SOFTRST;
                    cnt_clr = 1'b1;
                end
            end
            ST_SOFTRST: begin
                if (ext_s) nxt = ST_RESTART;                      // reset-end
            end
            default: nxt = ST_BACKUP;
        endcase
        if (!pwr_s) begin                                         // power-loss
            nxt     = ST_BACKUP;
            cnt_clr = 1'b1;
        end
    end

    // State register and shared interval counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_BACKUP;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (cnt_clr)             cnt <= '0;
            else if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
        end
    end

    // Outputs decoded from state
    always_comb begin
        reg_rst_n = 1'b0;
        gclk_en   = '0;
        backup    = 1'b0;
        unique case (state)
            ST_BACKUP:          backup = 1'b1;
            ST_RUN, ST_QUAL: begin
                reg_rst_n = 1'b1;
                gclk_en   = {NUM_GCLK{1'b1}};
            end
            ST_PWRUP, ST_RESTART, ST_SOFTRST: ;
            default:            backup = 1'b1;
        endcase
    end

    // Power loss wins over every other transition
    assert_backup_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_s |=> state == ST_BACKUP);

    // Leaving the power-up wait needs the full count
    assert_pwrup_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESTART && $past(state) == ST_PWRUP) |-> $past(cnt) == P_LAST);

    // Soft reset from qualification only after enough low samples
    assert_softrst_qual_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SOFTRST && $past(state) == ST_QUAL)
            |-> ($past(cnt) == M_LAST && !$past(ext_s)));

    // A high sample during qualification drops the request
    assert_short_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_QUAL && ext_s && pwr_s) |=> state == ST_RUN);

    // Running is entered from restart only after the full delay
    assert_restart_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && $past(state) != ST_RUN && $past(state) != ST_QUAL)
            |-> ($past(state) == ST_RESTART && $past(cnt) == R_LAST));
endmodule

// File: rtl/rbb_outforce.sv
module rbb_outforce #(
    parameter int TX_W    = 3,
    parameter int CKO_W   = 2,
    parameter int STRB_W  = 7,
    parameter int BIDIR_W = 8
) (
    input  logic               backup,
    input  logic [TX_W-1:0]    core_tx,
    input  logic [CKO_W-1:0]   core_clkout,
    input  logic [BIDIR_W-1:0] core_bidir_oe,
    output logic [TX_W-1:0]    tx_o,
    output logic [CKO_W-1:0]   clkout_o,
    output logic [STRB_W-1:0]  strb_oe_o,
    output logic [BIDIR_W-1:0] bidir_oe_o
);
    // Driven-low classes
    always_comb begin
        tx_o     = backup ? '0 : core_tx;
        clkout_o = backup ? '0 : core_clkout;
    end

    // High-impedance classes, per pin
    for (genvar i = 0; i < STRB_W; i++) begin : g_strb
        assign strb_oe_o[i] = ~backup;
    end
    for (genvar i = 0; i < BIDIR_W; i++) begin : g_bidir
        assign bidir_oe_o[i] = core_bidir_oe[i] & ~backup;
    end
endmodule

// File: rtl/rbb_ctrl.sv
module rbb_ctrl
    import rbb_pkg::*;
#(
    parameter int TMR_HZ      = 32768,
    parameter int PWRUP_US    = 100000,
    parameter int MINLOW_US   = 100,
    parameter int RESTART_CYC = 10,
    parameter int SYNC_STAGES = 2,
    parameter int NUM_GCLK    = 3,
    parameter int TX_W        = 3,
    parameter int CKO_W       = 2,
    parameter int STRB_W      = 7,
    parameter int BIDIR_W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_good,
    input  logic               ext_rst_n,
    input  logic [TX_W-1:0]    core_tx,
    input  logic [CKO_W-1:0]   core_clkout,
    input  logic [BIDIR_W-1:0] core_bidir_oe,
    output logic               reg_rst_n,
    output logic [NUM_GCLK-1:0] gclk_en,
    output logic               ram_retain,
    output logic [TX_W-1:0]    tx_o,
    output logic [CKO_W-1:0]   clkout_o,
    output logic [STRB_W-1:0]  strb_oe_o,
    output logic [BIDIR_W-1:0] bidir_oe_o
);
    localparam int PWRUP_CYC   = cyc_from_us(longint'(TMR_HZ), longint'(PWRUP_US));
    localparam int MIN_LOW_CYC = cyc_from_us(longint'(TMR_HZ), longint'(MINLOW_US));

    logic [1:0] raw_in, syn_in;
    logic       backup;

    assign raw_in = {ext_rst_n, pwr_good};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        rbb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw_in[g]),
            .q     (syn_in[g])
        );
    end

    rbb_seq #(
        .PWRUP_CYC   (PWRUP_CYC),
        .MIN_LOW_CYC (MIN_LOW_CYC),
        .RESTART_CYC (RESTART_CYC),
        .NUM_GCLK    (NUM_GCLK)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_s     (syn_in[0]),
        .ext_s     (syn_in[1]),
        .reg_rst_n (reg_rst_n),
        .gclk_en   (gclk_en),
        .backup    (backup)
    );

    rbb_outforce #(
        .TX_W    (TX_W),
        .CKO_W   (CKO_W),
        .STRB_W  (STRB_W),
        .BIDIR_W (BIDIR_W)
    ) u_force (
        .backup        (backup),
        .core_tx       (core_tx),
        .core_clkout   (core_clkout),
        .core_bidir_oe (core_bidir_oe),
        .tx_o          (tx_o),
        .clkout_o      (clkout_o),
        .strb_oe_o     (strb_oe_o),
        .bidir_oe_o    (bidir_oe_o)
    );

    assign ram_retain = backup;

    // Backup state seen by the sequencer implies safe pins from the forcing logic
    assert_force_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_retain |-> (tx_o == '0 && clkout_o == '0 && strb_oe_o == '0 && bidir_oe_o == '0));

    // No clock runs while the register reset is held
    assert_clk_with_rst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gclk_en != '0) |-> reg_rst_n);

    // Retention never overlaps a released register reset
    assert_retain_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ram_retain |-> (!reg_rst_n && gclk_en == '0));
endmodule

// File: tb/sim_rbb_ctrl.sv
module sim_rbb_ctrl;
    localparam int P  = 3277;   // 100 ms at 32768 Hz, rounded up
    localparam int M  = 4;      // 100 us at 32768 Hz, rounded up
    localparam int R  = 10;
    localparam int NG = 3;

    typedef struct packed {
        logic        pwr;
        logic        ext;
        logic [15:0] hold;
        logic        run;
        logic        ret;
        logic [7:0]  req;
    } vec_t;

    // Inputs applied at a falling edge, then 'hold' rising edges, then a check.
    localparam vec_t VEC [13] = '{
        '{1'b0, 1'b1, 16'd5,       1'b0, 1'b1, 8'd2},  // R2 settled backup
        '{1'b1, 1'b1, 16'd2,       1'b0, 1'b1, 8'd4},  // R4 edge 2: still backup
        '{1'b1, 1'b1, 16'(P+R),    1'b0, 1'b0, 8'd4},  // R4 edge P+R+2: held; R10
        '{1'b1, 1'b1, 16'd1,       1'b1, 1'b0, 8'd4},  // R4 edge P+R+3: released
        '{1'b1, 1'b0, 16'(M-1),    1'b1, 1'b0, 8'd7},  // R7 short pulse
        '{1'b1, 1'b1, 16'd20,      1'b1, 1'b0, 8'd7},  // R7 ignored
        '{1'b1, 1'b0, 16'(M+1),    1'b1, 1'b0, 8'd6},  // R6 edge M+1: still running
        '{1'b1, 1'b0, 16'd1,       1'b0, 1'b0, 8'd6},  // R6 edge M+2: soft reset
        '{1'b1, 1'b0, 16'd50,      1'b0, 1'b0, 8'd6},  // R6 stays in reset; R10
        '{1'b1, 1'b1, 16'(R+2),    1'b0, 1'b0, 8'd8},  // R8 edge R+2: held
        '{1'b1, 1'b1, 16'd1,       1'b1, 1'b0, 8'd8},  // R8 edge R+3: released
        '{1'b0, 1'b1, 16'd2,       1'b1, 1'b0, 8'd2},  // R2 edge 2: still running
        '{1'b0, 1'b1, 16'd1,       1'b0, 1'b1, 8'd2}   // R2 edge 3: backup; R3
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pwr = 1'b0;
    logic             ext = 1'b1;
    logic [2:0]       core_tx = 3'b111;
    logic [1:0]       core_clkout = 2'b11;
    logic [7:0]       core_bidir_oe = 8'hA5;
    logic             reg_rst_n, ram_retain;
    logic [NG-1:0]    gclk_en;
    logic [2:0]       tx_o;
    logic [1:0]       clkout_o;
    logic [6:0]       strb_oe_o;
    logic [7:0]       bidir_oe_o;

    int  checks = 0;
    int  errs   = 0;
    bit  done   = 1'b0;

    rbb_ctrl u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwr_good      (pwr),
        .ext_rst_n     (ext),
        .core_tx       (core_tx),
        .core_clkout   (core_clkout),
        .core_bidir_oe (core_bidir_oe),
        .reg_rst_n     (reg_rst_n),
        .gclk_en       (gclk_en),
        .ram_retain    (ram_retain),
        .tx_o          (tx_o),
        .clkout_o      (clkout_o),
        .strb_oe_o     (strb_oe_o),
        .bidir_oe_o    (bidir_oe_o)
    );

    always #10 clk = ~clk;

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(logic p, logic e, int n);
        pwr = p;
        ext = e;
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_out(string tag, logic run, logic ret);
        logic [19:0] pins_exp;
        pins_exp = ret ? 20'h0 : {core_tx, core_clkout, 7'h7F, core_bidir_oe};
        chk({tag, " reg_rst_n"}, longint'(reg_rst_n), longint'(run));
        chk({tag, " gclk_en"}, longint'(gclk_en), run ? longint'({NG{1'b1}}) : 64'd0);
        chk({tag, " ram_retain"}, longint'(ram_retain), longint'(ret));
        chk({tag, " pins R3"}, longint'({tx_o, clkout_o, strb_oe_o, bidir_oe_o}),
            longint'(pins_exp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset holds backup even with power present
        pwr = 1'b1;
        repeat (3) @(negedge clk);
        expect_out("R1 reset", 1'b0, 1'b1);
        rst_n = 1'b1;

        for (int i = 0; i < 13; i++) begin
            step(VEC[i].pwr, VEC[i].ext, int'(VEC[i].hold));
            expect_out($sformatf("R%0d row%0d", VEC[i].req, i), VEC[i].run, VEC[i].ret);
        end

        // R5: external reset held low past the power-up wait
        step(1'b1, 1'b0, P + R + 40);
        expect_out("R5 held low", 1'b0, 1'b0);
        step(1'b1, 1'b1, R + 2);
        expect_out("R5 edge R+2", 1'b0, 1'b0);
        step(1'b1, 1'b1, 1);
        expect_out("R5 edge R+3", 1'b1, 1'b0);

        // R9: low during restart delay restarts the count
        step(1'b1, 1'b0, 10);
        expect_out("R9 soft reset", 1'b0, 1'b0);
        step(1'b1, 1'b1, 5);
        step(1'b1, 1'b0, 1);
        step(1'b1, 1'b1, R + 2);
        expect_out("R9 recount held", 1'b0, 1'b0);
        step(1'b1, 1'b1, 1);
        expect_out("R9 released", 1'b1, 1'b0);

        // R2 / R10: power loss during soft reset
        step(1'b1, 1'b0, 10);
        expect_out("R10 soft reset no retain", 1'b0, 1'b0);
        step(1'b0, 1'b0, 2);
        expect_out("R2 softrst edge 2", 1'b0, 1'b0);
        step(1'b0, 1'b0, 1);
        expect_out("R2 softrst edge 3", 1'b0, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule